// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a raster display. A horizontal counter walks every line through four intervals (sync pulse, back porch, active pixels, front porch). A vertical counter walks every frame through the same four intervals, measured in whole lines. From these two counters the block drives horizontal sync, vertical sync and data enable, each with its own polarity, and it reports the position of the active pixel. It also raises single-cycle events: one at the start of each frame, one when vertical sync ends, and one when a pixel is due but the upstream fetch unit has no data ready.

Software programs eight interval lengths, a polarity word and a run bit through a simple write port. The counters advance only on cycles where the pixel enable input is high, so the block can run on a fast system clock with a pixel-rate strobe. The intended sequence is: clear the run bit, program the lengths, then set the run bit. While the generator runs, writes to the timing registers are ignored. The run bit and the polarity word can be written at any time.

Top module: `rtg_top`

## Requirements
- R1: Each line runs through the phases sync, back porch, active, front porch in that order. Horizontal sync is active exactly during the sync phase, which lasts the programmed sync length in pixel steps.
- R2: Active-length registers (address 4 horizontal, address 8 vertical) hold the count minus one: a value N gives N+1 active pixels or lines. Data enable is active only where both axes are in their active phase.
- R3: The vertical counter advances only when a horizontal line completes. Vertical sync is active during the whole lines of the vertical sync phase.
- R4: Polarity word (address 1): bit 0 selects vsync active-high, bit 1 hsync active-high, bit 2 data-enable active-high. A cleared bit selects active-low. Bits 3 and 4 appear unchanged on `data_hi` and `pclk_rise`.
- R5: While the run bit (address 0, bit 0) is clear, the counters stay at zero. hsync, vsync and data enable sit at their inactive levels, x and y read zero, and no event fires. The run bit and the polarity word read as zero after reset.
- R6: Setting the run bit starts the scan at the first pixel of horizontal sync on line 0. `frame_start` pulses for one pixel step at that point and at the same point of every later frame.
- R7: Writes to the eight timing registers (addresses 2 to 9) are ignored while the run bit is set.
- R8: During data enable, x and y give the zero-based pixel and line within the active area. Outside data enable, both read zero.
- R9: `vsync_evt` pulses once per frame, on the pixel step that ends the last line of vertical sync.
- R10: `underrun` pulses on a pixel step where data enable is active and `pix_valid` is low.
- R11: The counters advance only on cycles with `pix_en` high. Events are qualified by `pix_en`.
- R12: A sync or porch length of zero still occupies one pixel step or one line. Timing register addresses are: 2 h-sync, 3 h-back-porch, 5 h-front-porch, 6 v-sync, 7 v-back-porch, 9 v-front-porch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| pix_valid | input | 1 | Upstream pixel data available |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Data enable at programmed polarity |
| data_hi | output | 1 | Data polarity selection for the output stage |
| pclk_rise | output | 1 | Pixel clock edge selection for the output stage |
| x | output | CW | Active pixel column |
| y | output | CW | Active line row |
| frame_start | output | 1 | Frame start event |
| vsync_evt | output | 1 | End of vertical sync event |
| underrun | output | 1 | Pixel due with no data |

## Verification
The bench keeps the default counter width of 12 bits but programs tiny timings: 8-pixel lines and 6-line frames in the first pass, and shorter ones with zero-length porches in the second. With these sizes every frame wrap, every phase boundary and the vertical-sync event can be reached many times within a few hundred cycles. A reference model derives the expected levels from the pixel step count alone, with a modulo over the line and frame totals. It does not use a phase machine. A gated `pix_en` pattern, a timing write made while running, and a polarity change between runs cover the stepping, write-ignore and polarity rules.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam int ADDR_W = 4;
  localparam int NPH    = 4;
  localparam int A_CMD  = 0;
  localparam int A_POL  = 1;
  localparam int A_HBASE = 2;   // + phase index
  localparam int A_VBASE = 6;   // + phase index
  localparam int POL_W  = 5;
  localparam int POL_V  = 0;
  localparam int POL_H  = 1;
  localparam int POL_DE = 2;
  localparam int POL_DATA = 3;
  localparam int POL_PCLK = 4;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [CW-1:0]             wr_data,
  output logic                      run,
  output logic [POL_W-1:0]          pol,
  output logic [NPH-1:0][CW-1:0]    len_h,
  output logic [NPH-1:0][CW-1:0]    len_v
);
  logic                   run_d;
  logic [POL_W-1:0]       pol_d;
  logic [NPH-1:0][CW-1:0] len_h_d;
  logic [NPH-1:0][CW-1:0] len_v_d;

  always_comb begin
    run_d = run;
    pol_d = pol;
    if (wr_en && wr_addr == ADDR_W'(A_CMD)) run_d = wr_data[0];
    if (wr_en && wr_addr == ADDR_W'(A_POL)) pol_d = wr_data[POL_W-1:0];
  end

  for (genvar g = 0; g < NPH; g++) begin : g_len
    localparam logic [ADDR_W-1:0] HA = ADDR_W'(A_HBASE + g);
    localparam logic [ADDR_W-1:0] VA = ADDR_W'(A_VBASE + g);
    always_comb begin
      len_h_d[g] = len_h[g];
      len_v_d[g] = len_v[g];
      if (wr_en && !run && wr_addr == HA) len_h_d[g] = wr_data;
      if (wr_en && !run && wr_addr == VA) len_v_d[g] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      pol   <= '0;
      len_h <= '0;
      len_v <= '0;
    end else begin
      run   <= run_d;
      pol   <= pol_d;
      len_h <= len_h_d;
      len_v <= len_v_d;
    end
  end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   step,
  input  logic [NPH-1:0][CW-1:0] len,
  output phase_e                 ph,
  output logic [CW-1:0]          cnt,
  output logic                   ph_end,
  output logic                   wrap
);
  phase_e        ph_d;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] sel;
  logic [CW-1:0] last;

  always_comb begin
    sel = len[ph];
    if (ph == PH_ACT)    last = sel;
    else if (sel == '0)  last = '0;
    else                 last = sel - 1'b1;
  end

  assign ph_end = (cnt == last);
  assign wrap   = step && ph_end && (ph == PH_FRONT);

  always_comb begin
    ph_d  = ph;
    cnt_d = cnt;
    if (!run) begin
      ph_d  = PH_SYNC;
      cnt_d = '0;
    end else if (step) begin
      if (ph_end) begin
        ph_d  = phase_e'(ph + 2'd1);
        cnt_d = '0;
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_SYNC;
      cnt <= '0;
    end else begin
      ph  <= ph_d;
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/rtg_out.sv
module rtg_out
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic             run,
  input  logic             pix_en,
  input  logic             pix_valid,
  input  logic [POL_W-1:0] pol,
  input  phase_e           h_ph,
  input  phase_e           v_ph,
  input  logic [CW-1:0]    h_cnt,
  input  logic [CW-1:0]    v_cnt,
  input  logic             h_wrap,
  input  logic             v_end,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             data_hi,
  output logic             pclk_rise,
  output logic [CW-1:0]    x,
  output logic [CW-1:0]    y,
  output logic             frame_start,
  output logic             vsync_evt,
  output logic             underrun
);
  logic h_on, v_on, de_on;

  always_comb begin
    h_on  = run && (h_ph == PH_SYNC);
    v_on  = run && (v_ph == PH_SYNC);
    de_on = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);
    hsync = ~(h_on  ^ pol[POL_H]);
    vsync = ~(v_on  ^ pol[POL_V]);
    de    = ~(de_on ^ pol[POL_DE]);
    data_hi   = pol[POL_DATA];
    pclk_rise = pol[POL_PCLK];
    x = de_on ? h_cnt : '0;
    y = de_on ? v_cnt : '0;
    frame_start = run && pix_en && h_on && (h_cnt == '0) && v_on && (v_cnt == '0);
    vsync_evt   = h_wrap && (v_ph == PH_SYNC) && v_end;
    underrun    = pix_en && de_on && !pix_valid;
  end
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              pix_valid,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              data_hi,
  output logic              pclk_rise,
  output logic [CW-1:0]     x,
  output logic [CW-1:0]     y,
  output logic              frame_start,
  output logic              vsync_evt,
  output logic              underrun
);
  logic                   run;
  logic [POL_W-1:0]       pol;
  logic [NPH-1:0][CW-1:0] len_h, len_v;
  phase_e                 h_ph, v_ph;
  logic [CW-1:0]          h_cnt, v_cnt;
  logic                   h_end, v_end, h_wrap, v_wrap;
  logic                   h_step;

  assign h_step = run && pix_en;

  rtg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .pol(pol), .len_h(len_h), .len_v(len_v)
  );

  rtg_axis #(.CW(CW)) u_h (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_step), .len(len_h),
    .ph(h_ph), .cnt(h_cnt), .ph_end(h_end), .wrap(h_wrap)
  );

  rtg_axis #(.CW(CW)) u_v (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_wrap), .len(len_v),
    .ph(v_ph), .cnt(v_cnt), .ph_end(v_end), .wrap(v_wrap)
  );

  rtg_out #(.CW(CW)) u_out (
    .run(run), .pix_en(pix_en), .pix_valid(pix_valid), .pol(pol),
    .h_ph(h_ph), .v_ph(v_ph), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .h_wrap(h_wrap), .v_end(v_end),
    .hsync(hsync), .vsync(vsync), .de(de), .data_hi(data_hi),
    .pclk_rise(pclk_rise), .x(x), .y(y), .frame_start(frame_start),
    .vsync_evt(vsync_evt), .underrun(underrun)
  );
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             pix_valid,
  input logic             run,
  input logic [POL_W-1:0] pol,
  input phase_e           h_ph,
  input phase_e           v_ph,
  input logic [CW-1:0]    h_cnt,
  input logic [CW-1:0]    v_cnt,
  input logic [CW-1:0]    hd_last,
  input logic             h_wrap,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [CW-1:0]    x,
  input logic [CW-1:0]    y,
  input logic             frame_start,
  input logic             vsync_evt,
  input logic             underrun
);
  logic de_on;
  assign de_on = (de == pol[POL_DE]);

  assert_idle_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync != pol[POL_H]) && (vsync != pol[POL_V]) && !de_on && x == '0 && y == '0);

  assert_enable_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> h_ph == PH_SYNC && h_cnt == '0 && v_ph == PH_SYNC && v_cnt == '0);

  assert_frame_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_x_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (de_on && pix_en && x != hd_last) |=> (!run || x == CW'($past(x) + 1'b1)));

  assert_v_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !h_wrap) |=> (!run || ($stable(v_cnt) && $stable(v_ph))));

  assert_vevt_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_evt |=> (!run || v_ph == PH_BACK));

  assert_underrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> de_on && !pix_valid && pix_en);
endmodule

bind rtg_top rtg_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_valid(pix_valid),
  .run(run), .pol(pol), .h_ph(h_ph), .v_ph(v_ph), .h_cnt(h_cnt),
  .v_cnt(v_cnt), .hd_last(len_h[2]), .h_wrap(h_wrap), .hsync(hsync),
  .vsync(vsync), .de(de), .x(x), .y(y), .frame_start(frame_start),
  .vsync_evt(vsync_evt), .underrun(underrun)
);

// File: tb/rtg_top_tb.sv
module rtg_top_tb;
  localparam int CW = 12;

  logic          clk;
  logic          rst_n;
  logic          pix_en;
  logic          wr_en;
  logic [3:0]    wr_addr;
  logic [CW-1:0] wr_data;
  logic          pix_valid;
  logic          hsync, vsync, de, data_hi, pclk_rise;
  logic [CW-1:0] x, y;
  logic          frame_start, vsync_evt, underrun;

  rtg_top #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pix_valid(pix_valid),
    .hsync(hsync), .vsync(vsync), .de(de), .data_hi(data_hi),
    .pclk_rise(pclk_rise), .x(x), .y(y), .frame_start(frame_start),
    .vsync_evt(vsync_evt), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic    hs, vs, de, dh, pr, fs, ve, ur;
    int      x, y;
    string   scen;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // reference model state
  bit   m_en;
  int   m_k;
  int   m_pol;
  int   mh[4];
  int   mv[4];

  function automatic int pl(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic cyc(input bit pe, input bit pv, input bit we,
                     input int adr, input int dat, input string scen);
    exp_t e;
    int ht, vt, p, l, hst, vst;
    bit ha, va, hd, vd;
    @(negedge clk);
    pix_en = pe; pix_valid = pv; wr_en = we;
    wr_addr = 4'(adr); wr_data = CW'(dat);
    ht  = pl(mh[0]) + pl(mh[1]) + mh[2] + 1 + pl(mh[3]);
    vt  = pl(mv[0]) + pl(mv[1]) + mv[2] + 1 + pl(mv[3]);
    p   = m_k % ht;
    l   = (m_k / ht) % vt;
    hst = pl(mh[0]) + pl(mh[1]);
    vst = pl(mv[0]) + pl(mv[1]);
    ha  = m_en && p < pl(mh[0]);
    va  = m_en && l < pl(mv[0]);
    hd  = m_en && p >= hst && p <= hst + mh[2];
    vd  = m_en && l >= vst && l <= vst + mv[2];
    e.hs = ha ? m_pol[1] : !m_pol[1];
    e.vs = va ? m_pol[0] : !m_pol[0];
    e.de = (hd && vd) ? m_pol[2] : !m_pol[2];
    e.dh = m_pol[3];
    e.pr = m_pol[4];
    e.x  = (hd && vd) ? p - hst : 0;
    e.y  = (hd && vd) ? l - vst : 0;
    e.fs = m_en && pe && p == 0 && l == 0;
    e.ve = m_en && pe && p == ht - 1 && l == pl(mv[0]) - 1;
    e.ur = pe && hd && vd && !pv;
    e.scen = scen;
    q.push_back(e);
    // model update for the coming edge
    if (m_en && pe) m_k++;
    if (we) begin
      if (adr == 0) begin
        m_en = dat[0];
        if (!dat[0]) m_k = 0;
      end else if (adr == 1) m_pol = dat & 31;
      else if (!m_en && adr >= 2 && adr <= 5) mh[adr-2] = dat;
      else if (!m_en && adr >= 6 && adr <= 9) mv[adr-6] = dat;
    end
  endtask

  task automatic chk1(input string req, input string scen, input string fld,
                      input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, scen, fld, act, exp_v);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk1("R1", e.scen, "hsync", int'(hsync), int'(e.hs));
      chk1("R3", e.scen, "vsync", int'(vsync), int'(e.vs));
      chk1("R2", e.scen, "de", int'(de), int'(e.de));
      chk1("R4", e.scen, "pol outs", int'({pclk_rise, data_hi}), int'({e.pr, e.dh}));
      chk1("R8", e.scen, "x", int'(x), e.x);
      chk1("R8", e.scen, "y", int'(y), e.y);
      chk1("R6", e.scen, "frame_start", int'(frame_start), int'(e.fs));
      chk1("R9", e.scen, "vsync_evt", int'(vsync_evt), int'(e.ve));
      chk1("R10", e.scen, "underrun", int'(underrun), int'(e.ur));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_en = 0; m_k = 0; m_pol = 0;
    foreach (mh[i]) begin mh[i] = 0; mv[i] = 0; end
    pix_en = 0; pix_valid = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R5: reset state, idle outputs inactive
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, "R5_reset");

    // program: R4 polarity, R12 register map
    cyc(1, 1, 1, 1, 5'b00111, "R4_pol");
    cyc(1, 1, 1, 2, 2, "R12_prog");
    cyc(1, 1, 1, 3, 1, "R12_prog");
    cyc(1, 1, 1, 4, 3, "R2_prog");
    cyc(1, 1, 1, 5, 1, "R12_prog");
    cyc(1, 1, 1, 6, 1, "R12_prog");
    cyc(1, 1, 1, 7, 1, "R12_prog");
    cyc(1, 1, 1, 8, 1, "R2_prog");
    cyc(1, 1, 1, 9, 2, "R12_prog");
    // R6: enable starts at hsync line 0
    cyc(1, 1, 1, 0, 1, "R6_enable");
    // R1 R2 R3 R9 R10: two frames, gaps in pix_valid
    for (int i = 0; i < 100; i++) cyc(1, (i % 7) != 3, 0, 0, 0, "R1_frames");
    // R7: timing write while running is ignored
    cyc(1, 1, 1, 4, 5, "R7_ignore");
    cyc(1, 1, 1, 6, 3, "R7_ignore");
    for (int i = 0; i < 60; i++) cyc(1, 1, 0, 0, 0, "R7_after");
    // R11: gated stepping
    for (int i = 0; i < 150; i++) cyc((i % 3) != 0, (i % 5) != 2, 0, 0, 0, "R11_gated");
    // R5: disable returns to idle
    cyc(1, 1, 1, 0, 0, "R5_disable");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, "R5_idle");
    // R4: other polarity, R12: zero-length porches
    cyc(1, 1, 1, 1, 5'b11010, "R4_pol2");
    cyc(1, 1, 1, 5, 0, "R12_zero");
    cyc(1, 1, 1, 7, 0, "R12_zero");
    cyc(1, 1, 1, 4, 2, "R2_prog2");
    cyc(1, 1, 1, 0, 1, "R6_reenable");
    for (int i = 0; i < 120; i++) cyc(1, (i % 4) != 1, 0, 0, 0, "R12_frames");
    cyc(1, 1, 1, 0, 0, "R5_disable2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, "R5_idle2");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule